// File: doc/BRIEF.md
# Addressed Two-Wire Slave Front End

This block is the bus-facing half of a two-wire (I2C-style) slave. It runs on a fast system clock and oversamples the SCL and SDA lines. Each line passes through a two-flop synchroniser and a small majority vote, so short glitches are rejected. From the cleaned levels it detects START, repeated START and STOP conditions and SCL edges. It receives the slave address byte and compares it with a fixed device-type nibble and three pin-strapped bits. It then frames the following bytes for a register controller that sits behind it.

Written bytes are handed over as single-cycle strobes. The first byte after the address byte is a register-address strobe, and every later byte is a data strobe. Read bytes are requested from the controller one at a time and shifted out MSB first. SDA is only ever pulled low through an open-drain enable.

Two inputs gate the bus. While the controller reports a nonvolatile write in progress, no address byte is acknowledged, so the master can poll for completion. While the chip-select input is low, the interface is switched off completely.

Top module: `twi_slave_front`

## Requirements
- R1: The slave address byte carries the type nibble 4'b0101 in bits 7:4, the strap pins strap_i[2:0] in bits 3:1, and the direction in bit 0, where 1 means read. The slave pulls SDA low during the ninth clock only when bits 7:1 match.
- R2: After an address byte that does not match, SDA stays released and no strobe is produced until the next START or STOP. The bytes that follow are ignored.
- R3: SDA falling while SCL is high gives a one-cycle start_o pulse, and SDA rising while SCL is high gives a one-cycle stop_o pulse. A repeated START restarts address reception.
- R4: Bits are taken on SCL rising edges, MSB first. In a write, the first byte after the address byte raises addr_valid_o and each later byte raises wr_valid_o, with the byte on rx_byte_o. Every such byte is acknowledged.
- R5: In a read, rd_req_o pulses once per byte, and rd_data_i is taken at the second clock edge after the edge that raised rd_req_o. The byte is driven MSB first, and each bit changes only after an SCL falling edge. SDA is released for the ninth clock.
- R6: A master ACK (SDA low on the ninth clock) makes the slave request and send another byte. A NACK ends driving and requesting until the next START or STOP.
- R7: While nv_busy_i is high at the address decision, no address byte is acknowledged, whatever its direction bit, and no strobe follows.
- R8: While cs_i is low, SDA is never pulled and no strobe is produced, including start_o and stop_o. After cs_i rises, the slave waits for a fresh START.
- R9: A pulse of one system clock on SCL or SDA is filtered out. It creates no START, no STOP and no extra bit.
- R10: After reset all strobes are low and SDA is released. Every strobe lasts one cycle. sda_pull_o only asserts following an SCL falling edge, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select; low disables the interface |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| strap_i | input | 3 | Pin-strapped address bits |
| nv_busy_i | input | 1 | Nonvolatile write in progress |
| start_o | output | 1 | START or repeated START seen (pulse) |
| stop_o | output | 1 | STOP seen (pulse) |
| addr_valid_o | output | 1 | Register-address byte on rx_byte_o (pulse) |
| wr_valid_o | output | 1 | Write data byte on rx_byte_o (pulse) |
| rx_byte_o | output | 8 | Last received byte |
| rd_req_o | output | 1 | Request for the next read byte (pulse) |
| rd_data_i | input | 8 | Read byte from the controller |

## Verification
A bit counter that is off by one moves the acknowledge to the wrong clock. The master then sees a missing ACK at the ninth clock of the very first byte, and the byte strobes carry shifted values. A state that survives a NACK, a busy flag or a low chip select shows up as SDA pulled low during a later clock, or as a strobe where none is expected. Each of these is visible within one byte time of the fault. Filter or edge-detector faults appear as extra start_o pulses or corrupted strobe bytes in the transaction that contains the glitch.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 3;
  localparam int TYPE_W  = BYTE_W - 1 - STRAP_W;
  localparam logic [TYPE_W-1:0] TYPE_ID = 4'b0101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } link_state_t;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   VOTE_LEN    = 3,
  parameter logic IDLE_LVL    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic lvl_o
);
  localparam int CW = $clog2(VOTE_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_LEN-1:0]    win_q;
  logic [CW-1:0]          ones;
  logic                   vote;
  logic                   lvl_q;

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_LEN; i++) ones = ones + CW'(win_q[i]);
    vote = (ones > CW'(VOTE_LEN / 2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {SYNC_STAGES{IDLE_LVL}};
      win_q  <= {VOTE_LEN{IDLE_LVL}};
      lvl_q  <= IDLE_LVL;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      win_q  <= {win_q[VOTE_LEN-2:0], sync_q[SYNC_STAGES-1]};
      lvl_q  <= vote;
    end
  end

  assign lvl_o = lvl_q;

  AST_LVL_UNANIMOUS_HI: assert property (@(posedge clk) disable iff (rst)
    (&win_q) |=> lvl_q); // R9
  AST_LVL_UNANIMOUS_LO: assert property (@(posedge clk) disable iff (rst)
    (~|win_q) |=> !lvl_q); // R9
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic scl_lvl_i,
  input  logic sda_lvl_i,
  output logic ev_start_o,
  output logic ev_stop_o,
  output logic ev_rise_o,
  output logic ev_fall_o,
  output logic bit_o
);
  logic scl_prev, sda_prev;
  logic start_c, stop_c, rise_c, fall_c;

  assign start_c = scl_prev & scl_lvl_i & sda_prev & ~sda_lvl_i;
  assign stop_c  = scl_prev & scl_lvl_i & ~sda_prev & sda_lvl_i;
  assign rise_c  = ~scl_prev & scl_lvl_i;
  assign fall_c  = scl_prev & ~scl_lvl_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev   <= 1'b1;
      sda_prev   <= 1'b1;
      ev_start_o <= 1'b0;
      ev_stop_o  <= 1'b0;
      ev_rise_o  <= 1'b0;
      ev_fall_o  <= 1'b0;
      bit_o      <= 1'b1;
    end else begin
      scl_prev   <= scl_lvl_i;
      sda_prev   <= sda_lvl_i;
      ev_start_o <= en_i & start_c;
      ev_stop_o  <= en_i & stop_c;
      ev_rise_o  <= en_i & rise_c;
      ev_fall_o  <= en_i & fall_c;
      bit_o      <= sda_lvl_i;
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ev_start_o |=> !ev_start_o); // R3
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ev_rise_o && ev_fall_o)); // R4
endmodule

// File: rtl/twi_link_fsm.sv
module twi_link_fsm
  import twi_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               ev_start_i,
  input  logic               ev_stop_i,
  input  logic               ev_rise_i,
  input  logic               ev_fall_i,
  input  logic               bit_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               nv_busy_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               sda_pull_o,
  output logic               start_o,
  output logic               stop_o,
  output logic               addr_valid_o,
  output logic               wr_valid_o,
  output logic               rd_req_o,
  output logic [BYTE_W-1:0]  rx_byte_o
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  link_state_t       state;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] shreg, txreg;
  logic              is_read_q, first_q, mack_q, pull_q;
  logic [1:0]        rd_wait;
  logic              addr_hit;

  assign addr_hit = (shreg[BYTE_W-1 -: TYPE_W] == TYPE_ID)
                 && (shreg[STRAP_W:1] == strap_i) && !nv_busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      shreg        <= '0;
      txreg        <= '0;
      is_read_q    <= 1'b0;
      first_q      <= 1'b0;
      mack_q       <= 1'b0;
      pull_q       <= 1'b0;
      rd_wait      <= '0;
      start_o      <= 1'b0;
      stop_o       <= 1'b0;
      addr_valid_o <= 1'b0;
      wr_valid_o   <= 1'b0;
      rd_req_o     <= 1'b0;
      rx_byte_o    <= '0;
    end else begin
      start_o      <= 1'b0;
      stop_o       <= 1'b0;
      addr_valid_o <= 1'b0;
      wr_valid_o   <= 1'b0;
      rd_req_o     <= 1'b0;
      rd_wait      <= {rd_wait[0], 1'b0};
      if (rd_wait[1]) txreg <= rd_data_i;

      if (!en_i) begin
        state   <= ST_IDLE;
        pull_q  <= 1'b0;
        rd_wait <= '0;
      end else if (ev_start_i) begin
        start_o <= 1'b1;
        state   <= ST_ADDR;
        cnt     <= '0;
        pull_q  <= 1'b0;
      end else if (ev_stop_i) begin
        stop_o  <= 1'b1;
        state   <= ST_IDLE;
        pull_q  <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_RX: begin
            if (ev_rise_i && cnt != FULL) begin
              shreg <= {shreg[BYTE_W-2:0], bit_i};
              cnt   <= cnt + CW'(1);
            end else if (ev_fall_i && cnt == FULL) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  pull_q    <= 1'b1;
                  is_read_q <= shreg[0];
                  first_q   <= 1'b1;
                  state     <= ST_AACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                rx_byte_o    <= shreg;
                addr_valid_o <= first_q;
                wr_valid_o   <= !first_q;
                first_q      <= 1'b0;
                pull_q       <= 1'b1;
                state        <= ST_RACK;
              end
            end
          end
          ST_AACK: begin
            if (ev_rise_i && is_read_q) begin
              rd_req_o <= 1'b1;
              rd_wait  <= 2'b01;
            end else if (ev_fall_i) begin
              cnt <= '0;
              if (is_read_q) begin
                pull_q <= ~txreg[BYTE_W-1];
                state  <= ST_TX;
              end else begin
                pull_q <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_RACK: begin
            if (ev_fall_i) begin
              pull_q <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_TX: begin
            if (ev_fall_i) begin
              if (cnt == LAST) begin
                pull_q <= 1'b0;
                cnt    <= '0;
                state  <= ST_MACK;
              end else begin
                pull_q <= ~txreg[BYTE_W-2];
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                cnt    <= cnt + CW'(1);
              end
            end
          end
          ST_MACK: begin
            if (ev_rise_i) begin
              mack_q <= !bit_i;
              if (!bit_i) begin
                rd_req_o <= 1'b1;
                rd_wait  <= 2'b01;
              end
            end else if (ev_fall_i) begin
              if (mack_q) begin
                pull_q <= ~txreg[BYTE_W-1];
                cnt    <= '0;
                state  <= ST_TX;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && nv_busy_i) |=> !sda_pull_o); // R7
  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!sda_pull_o && !start_o && !stop_o)); // R8
  AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> $past(ev_fall_i)); // R10
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_o, stop_o, addr_valid_o, wr_valid_o, rd_req_o})); // R10
  AST_RDREQ_IN_READ: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> is_read_q); // R5
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sda_pull_o); // R2
endmodule

// File: rtl/twi_slave_front.sv
module twi_slave_front
  import twi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_LEN    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               nv_busy_i,
  output logic               start_o,
  output logic               stop_o,
  output logic               addr_valid_o,
  output logic               wr_valid_o,
  output logic [BYTE_W-1:0]  rx_byte_o,
  output logic               rd_req_o,
  input  logic [BYTE_W-1:0]  rd_data_i
);
  localparam int LINES = 3;
  localparam logic [LINES-1:0] LINE_IDLE = 3'b011;

  logic [LINES-1:0] raw_w, lvl_w;
  logic ev_start, ev_stop, ev_rise, ev_fall, bit_w;

  assign raw_w = {cs_i, sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    twi_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .VOTE_LEN   (VOTE_LEN),
      .IDLE_LVL   (LINE_IDLE[g])
    ) u_filt (
      .clk  (clk),
      .rst  (rst),
      .raw_i(raw_w[g]),
      .lvl_o(lvl_w[g])
    );
  end

  twi_bus_events u_events (
    .clk       (clk),
    .rst       (rst),
    .en_i      (lvl_w[2]),
    .scl_lvl_i (lvl_w[0]),
    .sda_lvl_i (lvl_w[1]),
    .ev_start_o(ev_start),
    .ev_stop_o (ev_stop),
    .ev_rise_o (ev_rise),
    .ev_fall_o (ev_fall),
    .bit_o     (bit_w)
  );

  twi_link_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .en_i        (lvl_w[2]),
    .ev_start_i  (ev_start),
    .ev_stop_i   (ev_stop),
    .ev_rise_i   (ev_rise),
    .ev_fall_i   (ev_fall),
    .bit_i       (bit_w),
    .strap_i     (strap_i),
    .nv_busy_i   (nv_busy_i),
    .rd_data_i   (rd_data_i),
    .sda_pull_o  (sda_pull_o),
    .start_o     (start_o),
    .stop_o      (stop_o),
    .addr_valid_o(addr_valid_o),
    .wr_valid_o  (wr_valid_o),
    .rd_req_o    (rd_req_o),
    .rx_byte_o   (rx_byte_o)
  );
endmodule

// File: tb/twi_slave_front_bench.sv
module twi_slave_front_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b1, m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic [2:0] strap = 3'b010;
  logic sda_pull_o, start_o, stop_o, addr_valid_o, wr_valid_o, rd_req_o;
  logic [7:0] rx_byte_o, rd_data;
  wire sda_bus = m_sda & ~sda_pull_o;

  int n_tests = 0, n_fail = 0;
  int n_start = 0, n_stop = 0, n_addr = 0, n_wr = 0, n_rd = 0, n_pull = 0, n_viol = 0;
  logic [7:0] last_addr = 8'h00;
  logic [7:0] wr_log [8];
  logic [7:0] rd_tab [8];
  logic [4:0] strb_prev = '0;
  logic pull_prev = 1'b0;
  logic [2:0] rd_sel;

  assign rd_sel  = 3'(n_rd + 7);
  assign rd_data = rd_tab[rd_sel];

  always #2 clk = ~clk;

  twi_slave_front u_twi_slave_front (
    .clk(clk), .rst(rst), .cs_i(cs), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull_o), .strap_i(strap), .nv_busy_i(busy),
    .start_o(start_o), .stop_o(stop_o), .addr_valid_o(addr_valid_o),
    .wr_valid_o(wr_valid_o), .rx_byte_o(rx_byte_o), .rd_req_o(rd_req_o),
    .rd_data_i(rd_data)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (start_o) n_start <= n_start + 1;
      if (stop_o) n_stop <= n_stop + 1;
      if (addr_valid_o) begin n_addr <= n_addr + 1; last_addr <= rx_byte_o; end
      if (wr_valid_o) begin wr_log[3'(n_wr)] <= rx_byte_o; n_wr <= n_wr + 1; end
      if (rd_req_o) n_rd <= n_rd + 1;
      if (sda_pull_o) n_pull <= n_pull + 1;
      if (({start_o, stop_o, addr_valid_o, wr_valid_o, rd_req_o} & strb_prev) != 0) n_viol <= n_viol + 1;
      if (sda_pull_o && !pull_prev && m_scl) n_viol <= n_viol + 1;
      strb_prev <= {start_o, stop_o, addr_valid_o, wr_valid_o, rd_req_o};
      pull_prev <= sda_pull_o;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, input logic g, output logic s);
    hq(); m_sda = b;
    if (g) begin
      repeat (3) @(negedge clk); m_scl = 1'b1;
      @(negedge clk); m_scl = 1'b0;
    end
    hq(); m_scl = 1'b1;
    hq(); s = sda_bus;
    hq(); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input logic g, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(v[i], g, s);
    bit_io(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, 1'b0, s); v[i] = s; end
    bit_io(~mack, 1'b0, s);
  endtask

  task automatic go_start();
    hq(); m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); m_sda = 1'b0; hq(); m_scl = 1'b0;
  endtask

  task automatic go_stop();
    hq(); m_sda = 1'b0; hq(); m_scl = 1'b1; hq(); m_sda = 1'b1; hq();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // {slave byte, register byte, data byte, expected ack}; strap = 3'b010
  localparam logic [24:0] WVEC [6] = '{
    {8'h54, 8'h00, 8'hA5, 1'b1},
    {8'h54, 8'h07, 8'h3C, 1'b1},
    {8'h50, 8'h01, 8'h11, 1'b0},
    {8'h74, 8'h02, 8'h22, 1'b0},
    {8'h56, 8'h05, 8'h33, 1'b0},
    {8'h54, 8'hFF, 8'h00, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] rb;
    int b_st, b_sp, b_ad, b_wr, b_rd, b_pl;
    rd_tab = '{8'hC3, 8'h5A, 8'h81, 8'h7E, 8'h00, 8'hFF, 8'h96, 8'h24};
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    // R10: reset state
    chk("R10 reset pull", sda_pull_o, 0);
    chk("R10 reset strobes", {start_o, stop_o, addr_valid_o, wr_valid_o, rd_req_o}, 0);

    // R1 R2 R3 R4: table-driven single-byte writes
    for (int k = 0; k < 6; k++) begin
      b_st = n_start; b_sp = n_stop; b_ad = n_addr; b_wr = n_wr; b_pl = n_pull;
      go_start();
      send_byte(WVEC[k][24:17], 1'b0, a0);
      send_byte(WVEC[k][16:9], 1'b0, a1);
      send_byte(WVEC[k][8:1], 1'b0, a2);
      go_stop();
      repeat (20) @(negedge clk);
      chk("R1 address ack", a0, WVEC[k][0]);
      chk("R3 start count", n_start - b_st, 1);
      chk("R3 stop count", n_stop - b_sp, 1);
      if (WVEC[k][0]) begin
        chk("R4 byte acks", {a1, a2}, 2'b11);
        chk("R4 addr strobe", n_addr - b_ad, 1);
        chk("R4 addr byte", last_addr, WVEC[k][16:9]);
        chk("R4 data byte", wr_log[3'(b_wr)], WVEC[k][8:1]);
      end else begin
        chk("R2 no strobes", (n_addr - b_ad) + (n_wr - b_wr), 0);
        chk("R2 sda released", n_pull - b_pl, 0);
      end
    end

    // R4: burst write of three data bytes
    b_wr = n_wr; b_ad = n_addr;
    go_start();
    send_byte(8'h54, 1'b0, a0); send_byte(8'h10, 1'b0, a1);
    send_byte(8'h01, 1'b0, a2); chk("R4 burst ack0", a2, 1);
    send_byte(8'h80, 1'b0, a2); chk("R4 burst ack1", a2, 1);
    send_byte(8'hFE, 1'b0, a2); chk("R4 burst ack2", a2, 1);
    go_stop();
    repeat (20) @(negedge clk);
    chk("R4 burst count", n_wr - b_wr, 3);
    chk("R4 burst b0", wr_log[3'(b_wr)], 8'h01);
    chk("R4 burst b1", wr_log[3'(b_wr + 1)], 8'h80);
    chk("R4 burst b2", wr_log[3'(b_wr + 2)], 8'hFE);

    // R3 R5 R6: random read with repeated START
    b_st = n_start; b_rd = n_rd;
    go_start();
    send_byte(8'h54, 1'b0, a0); send_byte(8'h03, 1'b0, a1);
    go_start();
    send_byte(8'h55, 1'b0, a0);
    chk("R1 read address ack", a0, 1);
    recv_byte(1'b1, rb); chk("R5 read byte0", rb, rd_tab[3'(b_rd)]);
    recv_byte(1'b1, rb); chk("R6 read byte1 after ACK", rb, rd_tab[3'(b_rd + 1)]);
    recv_byte(1'b0, rb); chk("R6 read byte2", rb, rd_tab[3'(b_rd + 2)]);
    recv_byte(1'b0, rb); chk("R6 silent after NACK", rb, 8'hFF);
    go_stop();
    repeat (20) @(negedge clk);
    chk("R3 repeated start count", n_start - b_st, 2);
    chk("R6 request count", n_rd - b_rd, 3);

    // R7: busy withholds ack for both directions
    busy = 1'b1; b_ad = n_addr; b_rd = n_rd;
    go_start(); send_byte(8'h55, 1'b0, a0); go_stop();
    chk("R7 busy read nack", a0, 0);
    go_start(); send_byte(8'h54, 1'b0, a0); send_byte(8'h01, 1'b0, a1); go_stop();
    chk("R7 busy write nack", {a0, a1}, 0);
    repeat (20) @(negedge clk);
    chk("R7 busy no strobes", (n_addr - b_ad) + (n_rd - b_rd), 0);
    busy = 1'b0;
    go_start(); send_byte(8'h54, 1'b0, a0); go_stop();
    chk("R7 ack after busy clears", a0, 1);

    // R8: chip select low disables everything
    cs = 1'b0; hq();
    b_st = n_start; b_sp = n_stop; b_ad = n_addr; b_wr = n_wr; b_pl = n_pull;
    go_start();
    send_byte(8'h54, 1'b0, a0); send_byte(8'h02, 1'b0, a1); send_byte(8'h44, 1'b0, a2);
    go_stop();
    repeat (20) @(negedge clk);
    chk("R8 off no ack", {a0, a1, a2}, 0);
    chk("R8 off no start/stop", (n_start - b_st) + (n_stop - b_sp), 0);
    chk("R8 off no strobes", (n_addr - b_ad) + (n_wr - b_wr), 0);
    chk("R8 off released", n_pull - b_pl, 0);
    go_start(); cs = 1'b1;
    send_byte(8'h54, 1'b0, a0); go_stop();
    chk("R8 waits for fresh START", a0, 0);
    go_start(); send_byte(8'h54, 1'b0, a0); go_stop();
    chk("R8 works after enable", a0, 1);

    // R9: glitch rejection
    b_st = n_start; b_ad = n_addr;
    hq(); m_sda = 1'b0; @(negedge clk); m_sda = 1'b1; hq(); hq();
    chk("R9 sda glitch no start", n_start - b_st, 0);
    go_start();
    send_byte(8'h54, 1'b1, a0); send_byte(8'h2B, 1'b1, a1);
    go_stop();
    repeat (20) @(negedge clk);
    chk("R9 glitched acks", {a0, a1}, 2'b11);
    chk("R9 glitched byte", last_addr, 8'h2B);
    chk("R9 start count", n_start - b_st, 1);

    chk("R10 strobe width and pull timing", n_viol, 0);
    summary();
  end
endmodule